// File: doc/BRIEF.md
# Video Port Host Slave Interface

This block is the slave end of a narrow host bus through which an external graphics master reaches a video device. Address, command and data all travel over one multiplexed nibble-wide bus, framed by a transaction-active input. The block assembles the nibbles into a 12-bit address and a command, then moves whole bytes: it gathers write nibbles into a byte for the register file and splits register or FIFO read bytes back into nibbles for the master.

Addresses split into a small configuration space, which the block serves itself (a power command byte and a power status byte), and a local register space, which it passes to the device's register file through a simple strobe interface. Register reads take one wait phase per byte so the register file has a full cycle to answer; register writes and FIFO reads take none. During reset the block pulls bus bit 0 low, and it releases that line when reset ends so the master can see a slave is present.

Top module: `vport_host_slave`

## Requirements
- R1: A transaction starts in the first cycle `txn_act` is high; the 12-bit address arrives over three phases, low nibble first, followed by one command nibble where bit 0 = 1 means write, bit 1 = 1 means FIFO access, and bits 3:2 hold the byte count minus one (1 to 4 bytes).
- R2: Addresses 0x000 to 0x00F belong to the configuration space and never raise `reg_wr_en` or `reg_rd_en`; addresses 0x010 to 0x0FF are implemented local registers and are reached through those strobes with `reg_addr` set.
- R3: A register read spends exactly one wait phase (`bus_wait` high) before the two data nibbles of each byte; register writes have no wait phase.
- R4: A FIFO read has no wait phase: data nibbles follow the command phase directly, taken from `fifo_rdata` low nibble first, and `fifo_pop` is high once per byte, in its high-nibble phase.
- R5: The FIFO is read-only: a FIFO write consumes its data phases and raises neither `fifo_pop` nor a register strobe.
- R6: While `rst` is high, `bus_oe` is 4'b0001 and `bus_out[0]` is 0; after reset, `bus_oe` is 4'b1111 in read data phases and 4'b0000 in every other phase.
- R7: In a burst the address steps by one per byte and holds at the top of its space (0x00F in configuration space, 0xFFF in local space) without entering the other space.
- R8: Unimplemented addresses (configuration addresses other than 0x00E and 0x00F, local addresses above 0x0FF) read as zero and discard writes without any strobe; 0x00E is read-only.
- R9: A write to 0x00F stores the byte, which reads back from 0x00F; its bits 1:0 drive `pwr_state`, and a read of 0x00E returns `pwr_state` zero-extended to a byte. Both are zero after reset.
- R10: Dropping `txn_act` in any phase ends the transaction at once, with no strobe in that phase; after the last byte the block ignores the bus until `txn_act` goes low.

Top module port order follows the list below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host interface clock |
| rst | input | 1 | Synchronous reset, active high |
| txn_act | input | 1 | Transaction frame from the master |
| bus_in | input | 4 | Nibble driven by the master |
| bus_out | output | 4 | Nibble driven by the slave |
| bus_oe | output | 4 | Per-bit output enable for `bus_out` |
| bus_wait | output | 1 | High during a wait phase |
| reg_addr | output | 12 | Register address for the register file |
| reg_wdata | output | 8 | Register write byte |
| reg_wr_en | output | 1 | Register write strobe |
| reg_rd_en | output | 1 | Register read strobe |
| reg_rdata | input | 8 | Register read byte, valid in the strobe cycle |
| fifo_rdata | input | 8 | Head byte of the output FIFO |
| fifo_pop | output | 1 | Removes the FIFO head byte |
| pwr_state | output | 2 | Power state set through configuration space |

## Verification
Clocked assertions watch, on every cycle, that local strobes only carry addresses inside the implemented local range, that wait phases never come back to back, that a FIFO pop is never preceded by a wait and happens only while read data is on the bus, that the bus after reset is either fully driven or released, that a configuration burst never leaves configuration space, and that a power command write is stored. The bench scenarios show what needs an expected value: the nibble order of address and data, the exact count of wait phases per transaction, the bytes returned by bursts, the zero reads and silent writes at unimplemented addresses, saturation at 0xFFF, the presence level during reset, and abort and trailing-phase behaviour.

// File: rtl/vph_pkg.sv
package vph_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_CMD,
        S_WAIT,
        S_DATA,
        S_END
    } vph_state_e;

    // Command nibble layout
    localparam int CMD_WR_BIT   = 0;
    localparam int CMD_FIFO_BIT = 1;
    localparam int CMD_LEN_LSB  = 2;
    localparam int LEN_W        = 2;

endpackage

// File: rtl/vph_decode.sv
module vph_decode #(
    parameter int          ADDR_W     = 12,
    parameter int unsigned CFG_TOP    = 'h00F,
    parameter int unsigned LOCAL_LAST = 'h0FF
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_cfg,
    output logic              local_hit,
    output logic              at_top,
    output logic              is_cmd,
    output logic              is_stat
);
    localparam logic [ADDR_W-1:0] CFG_END   = ADDR_W'(CFG_TOP);
    localparam logic [ADDR_W-1:0] LOC_END   = ADDR_W'(LOCAL_LAST);
    localparam logic [ADDR_W-1:0] CMD_ADDR  = CFG_END;
    localparam logic [ADDR_W-1:0] STAT_ADDR = CFG_END - 1'b1;

    always_comb begin
        in_cfg    = (addr <= CFG_END);
        local_hit = !in_cfg && (addr <= LOC_END);
        at_top    = in_cfg ? (addr == CFG_END) : (addr == '1);
        is_cmd    = (addr == CMD_ADDR);
        is_stat   = (addr == STAT_ADDR);
    end

endmodule

// File: rtl/vph_cfg_regs.sv
module vph_cfg_regs #(
    parameter int BYTE_W = 8,
    parameter int PWR_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] cmd_q,
    output logic [PWR_W-1:0]  pwr_state
);
    logic [BYTE_W-1:0] cmd_d;

    always_comb begin
        cmd_d = cmd_q;
        if (wr_en) cmd_d = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) cmd_q <= '0;
        else     cmd_q <= cmd_d;
    end

    assign pwr_state = cmd_q[PWR_W-1:0];

    assert_cmd_store_R9: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> cmd_q == $past(wdata));

endmodule

// File: rtl/vph_bus_drive.sv
module vph_bus_drive #(
    parameter int NIB_W = 4
) (
    input  logic             rst,
    input  logic             drive_en,
    input  logic [NIB_W-1:0] nib,
    output logic [NIB_W-1:0] bus_out,
    output logic [NIB_W-1:0] bus_oe
);
    always_comb begin
        if (rst) begin
            // presence level: bit 0 pulled low, rest released
            bus_oe  = NIB_W'(1);
            bus_out = '0;
        end else if (drive_en) begin
            bus_oe  = '1;
            bus_out = nib;
        end else begin
            bus_oe  = '0;
            bus_out = '0;
        end
    end

endmodule

// File: rtl/vport_host_slave.sv
module vport_host_slave
    import vph_pkg::*;
#(
    parameter int          ADDR_W     = 12,
    parameter int          NIB_W      = 4,
    parameter int          BYTE_W     = 8,
    parameter int          PWR_W      = 2,
    parameter int unsigned CFG_TOP    = 'h00F,
    parameter int unsigned LOCAL_LAST = 'h0FF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              txn_act,
    input  logic [NIB_W-1:0]  bus_in,
    output logic [NIB_W-1:0]  bus_out,
    output logic [NIB_W-1:0]  bus_oe,
    output logic              bus_wait,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_wr_en,
    output logic              reg_rd_en,
    input  logic [BYTE_W-1:0] reg_rdata,
    input  logic [BYTE_W-1:0] fifo_rdata,
    output logic              fifo_pop,
    output logic [PWR_W-1:0]  pwr_state
);
    localparam int ADDR_NIBS = ADDR_W / NIB_W;
    localparam int DATA_NIBS = BYTE_W / NIB_W;
    localparam int NIB_MAX   = (ADDR_NIBS > DATA_NIBS) ? ADDR_NIBS : DATA_NIBS;
    localparam int NIB_IDX_W = (NIB_MAX > 2) ? $clog2(NIB_MAX) : 1;
    localparam logic [NIB_IDX_W-1:0] ADDR_LAST = NIB_IDX_W'(ADDR_NIBS - 1);
    localparam logic [NIB_IDX_W-1:0] DATA_LAST = NIB_IDX_W'(DATA_NIBS - 1);
    localparam logic [ADDR_W-1:0]    CFG_END   = ADDR_W'(CFG_TOP);
    localparam logic [ADDR_W-1:0]    LOC_END   = ADDR_W'(LOCAL_LAST);

    typedef struct packed {
        vph_state_e             state;
        logic [NIB_IDX_W-1:0]   nib;
        logic [ADDR_W-1:0]      addr;
        logic                   wr;
        logic                   fifo;
        logic [LEN_W-1:0]       left;
        logic [BYTE_W-1:0]      rdata;
        logic [BYTE_W-1:0]      wdata;
    } seq_t;

    seq_t st_q, st_d;

    logic              in_cfg, local_hit, at_top, is_cmd, is_stat;
    logic [BYTE_W-1:0] cmd_q;
    logic              cfg_wr_d;
    logic              drive_d;
    logic [NIB_W-1:0]  drive_nib_d;
    logic              wait_d, reg_wr_d, reg_rd_d, pop_d;
    logic [BYTE_W-1:0] wbyte_d;
    logic [BYTE_W-1:0] rsrc_d;

    vph_decode #(
        .ADDR_W     (ADDR_W),
        .CFG_TOP    (CFG_TOP),
        .LOCAL_LAST (LOCAL_LAST)
    ) i_decode (
        .addr      (st_q.addr),
        .in_cfg    (in_cfg),
        .local_hit (local_hit),
        .at_top    (at_top),
        .is_cmd    (is_cmd),
        .is_stat   (is_stat)
    );

    vph_cfg_regs #(
        .BYTE_W (BYTE_W),
        .PWR_W  (PWR_W)
    ) i_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cfg_wr_d),
        .wdata     (wbyte_d),
        .cmd_q     (cmd_q),
        .pwr_state (pwr_state)
    );

    vph_bus_drive #(
        .NIB_W (NIB_W)
    ) i_drive (
        .rst      (rst),
        .drive_en (drive_d),
        .nib      (drive_nib_d),
        .bus_out  (bus_out),
        .bus_oe   (bus_oe)
    );

    always_comb begin
        st_d        = st_q;
        cfg_wr_d    = 1'b0;
        drive_d     = 1'b0;
        drive_nib_d = '0;
        wait_d      = 1'b0;
        reg_wr_d    = 1'b0;
        reg_rd_d    = 1'b0;
        pop_d       = 1'b0;
        rsrc_d      = st_q.fifo ? fifo_rdata : st_q.rdata;

        // write byte with the current nibble merged in
        wbyte_d = st_q.wdata;
        for (int i = 0; i < DATA_NIBS; i++) begin
            if (st_q.nib == NIB_IDX_W'(i)) wbyte_d[i*NIB_W +: NIB_W] = bus_in;
        end

        unique case (st_q.state)
            S_IDLE: begin
                if (txn_act) begin
                    st_d.addr              = '0;
                    st_d.addr[NIB_W-1:0]   = bus_in;
                    st_d.nib               = NIB_IDX_W'(1);
                    st_d.state             = S_ADDR;
                end
            end
            S_ADDR: begin
                for (int i = 0; i < ADDR_NIBS; i++) begin
                    if (st_q.nib == NIB_IDX_W'(i)) st_d.addr[i*NIB_W +: NIB_W] = bus_in;
                end
                if (st_q.nib == ADDR_LAST) begin
                    st_d.nib   = '0;
                    st_d.state = S_CMD;
                end else begin
                    st_d.nib = st_q.nib + 1'b1;
                end
            end
            S_CMD: begin
                st_d.wr    = bus_in[CMD_WR_BIT];
                st_d.fifo  = bus_in[CMD_FIFO_BIT];
                st_d.left  = bus_in[CMD_LEN_LSB +: LEN_W];
                st_d.wdata = '0;
                st_d.nib   = '0;
                st_d.state = (!bus_in[CMD_WR_BIT] && !bus_in[CMD_FIFO_BIT]) ? S_WAIT : S_DATA;
            end
            S_WAIT: begin
                wait_d   = 1'b1;
                reg_rd_d = local_hit;
                if (local_hit)    st_d.rdata = reg_rdata;
                else if (is_stat) st_d.rdata = BYTE_W'(pwr_state);
                else if (is_cmd)  st_d.rdata = cmd_q;
                else              st_d.rdata = '0;
                st_d.nib   = '0;
                st_d.state = S_DATA;
            end
            S_DATA: begin
                if (!st_q.wr) begin
                    drive_d = 1'b1;
                    for (int i = 0; i < DATA_NIBS; i++) begin
                        if (st_q.nib == NIB_IDX_W'(i)) drive_nib_d = rsrc_d[i*NIB_W +: NIB_W];
                    end
                end else begin
                    st_d.wdata = wbyte_d;
                end
                if (st_q.nib == DATA_LAST) begin
                    if (st_q.wr && !st_q.fifo) begin
                        reg_wr_d = local_hit;
                        cfg_wr_d = is_cmd;
                    end
                    pop_d    = !st_q.wr && st_q.fifo;
                    st_d.nib = '0;
                    if (st_q.left == '0) begin
                        st_d.state = S_END;
                    end else begin
                        st_d.left = st_q.left - 1'b1;
                        if (!st_q.fifo && !at_top) st_d.addr = st_q.addr + 1'b1;
                        st_d.state = (!st_q.wr && !st_q.fifo) ? S_WAIT : S_DATA;
                    end
                end else begin
                    st_d.nib = st_q.nib + 1'b1;
                end
            end
            S_END: begin
                st_d.state = S_END;
            end
            default: st_d.state = S_IDLE;
        endcase

        // frame dropped: abandon the transaction, no strobes this phase
        if (!txn_act) begin
            st_d.state  = S_IDLE;
            st_d.nib    = '0;
            cfg_wr_d    = 1'b0;
            drive_d     = 1'b0;
            drive_nib_d = '0;
            wait_d      = 1'b0;
            reg_wr_d    = 1'b0;
            reg_rd_d    = 1'b0;
            pop_d       = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign bus_wait  = wait_d;
    assign reg_addr  = st_q.addr;
    assign reg_wdata = wbyte_d;
    assign reg_wr_en = reg_wr_d;
    assign reg_rd_en = reg_rd_d;
    assign fifo_pop  = pop_d;

    assert_local_range_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en || reg_rd_en) |-> (reg_addr > CFG_END && reg_addr <= LOC_END));

    assert_single_wait_R3: assert property (@(posedge clk) disable iff (rst)
        bus_wait |=> !bus_wait);

    assert_pop_no_wait_R4: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> !$past(bus_wait));

    assert_pop_once_R4: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |=> !fifo_pop);

    assert_pop_on_read_R5: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> (bus_oe == '1));

    assert_bus_release_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_oe != '0) |-> (bus_oe == '1));

    assert_cfg_stay_R7: assert property (@(posedge clk) disable iff (rst)
        ((st_q.state == S_WAIT || st_q.state == S_DATA)
         && $past(st_q.state == S_WAIT || st_q.state == S_DATA)
         && $past(st_q.addr <= CFG_END)) |-> (st_q.addr <= CFG_END));

endmodule

// File: tb/test_vport_host_slave.sv
module test_vport_host_slave;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        txn_act = 1'b0;
    logic [3:0]  bus_in = '0;
    logic [3:0]  bus_out, bus_oe;
    logic        bus_wait;
    logic [11:0] reg_addr;
    logic [7:0]  reg_wdata, reg_rdata, fifo_rdata;
    logic        reg_wr_en, reg_rd_en, fifo_pop;
    logic [1:0]  pwr_state;

    always #5 clk = ~clk;

    vport_host_slave i_vport_host_slave (
        .clk        (clk),
        .rst        (rst),
        .txn_act    (txn_act),
        .bus_in     (bus_in),
        .bus_out    (bus_out),
        .bus_oe     (bus_oe),
        .bus_wait   (bus_wait),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_wr_en  (reg_wr_en),
        .reg_rd_en  (reg_rd_en),
        .reg_rdata  (reg_rdata),
        .fifo_rdata (fifo_rdata),
        .fifo_pop   (fifo_pop),
        .pwr_state  (pwr_state)
    );

    // register file and FIFO models
    logic [7:0]  mem [256];
    logic [7:0]  fval = 8'hA0;
    int          nwr = 0, nrd = 0, npop = 0;
    logic [11:0] last_wr_addr = '0;

    assign reg_rdata  = mem[reg_addr[7:0]];
    assign fifo_rdata = fval;

    always @(posedge clk) begin
        if (reg_wr_en) begin
            mem[reg_addr[7:0]] <= reg_wdata;
            last_wr_addr       <= reg_addr;
            nwr                <= nwr + 1;
        end
        if (reg_rd_en) nrd <= nrd + 1;
        if (fifo_pop) begin
            fval <= fval + 8'd1;
            npop <= npop + 1;
        end
    end

    int checks = 0, fails = 0;
    logic [7:0] wbuf [4];
    logic [7:0] rbuf [4];
    int waits, oe_err;
    logic s_wait;
    logic [3:0] s_out, s_oe;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one bus phase: drive at the falling edge, sample just after
    task automatic phase(input logic act, input logic [3:0] nib, input logic [3:0] oe_exp);
        @(negedge clk);
        txn_act = act;
        bus_in  = nib;
        #1;
        s_wait = bus_wait;
        s_out  = bus_out;
        s_oe   = bus_oe;
        if (s_wait) waits++;
        if (s_oe !== oe_exp) oe_err++;
    endtask

    task automatic xfer(input logic [11:0] a, input bit wr, input bit fifo, input int n, input int extra);
        logic [3:0] lo;
        waits  = 0;
        oe_err = 0;
        phase(1'b1, a[3:0], 4'h0);
        phase(1'b1, a[7:4], 4'h0);
        phase(1'b1, a[11:8], 4'h0);
        phase(1'b1, {2'(n - 1), fifo, wr}, 4'h0);
        for (int b = 0; b < n; b++) begin
            if (!wr && !fifo) phase(1'b1, 4'h0, 4'h0);
            phase(1'b1, wbuf[b][3:0], wr ? 4'h0 : 4'hF);
            lo = s_out;
            phase(1'b1, wbuf[b][7:4], wr ? 4'h0 : 4'hF);
            rbuf[b] = {s_out, lo};
        end
        for (int e = 0; e < extra; e++) phase(1'b1, 4'hF, 4'h0);
        phase(1'b0, 4'h0, 4'h0);
    endtask

    task automatic wr1(input logic [11:0] a, input logic [7:0] v);
        wbuf[0] = v;
        xfer(a, 1'b1, 1'b0, 1, 0);
    endtask

    task automatic rd1(input logic [11:0] a);
        wbuf[0] = 8'h00;
        xfer(a, 1'b0, 1'b0, 1, 0);
    endtask

    task automatic t_reset;
        @(negedge clk); #1;
        check("R6 presence oe in reset", bus_oe, 4'b0001);
        check("R6 presence level in reset", bus_out[0], 1'b0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        check("R6 released after reset", bus_oe, 4'b0000);
        check("R9 power state after reset", pwr_state, 2'd0);
    endtask

    task automatic t_single;
        int w0;
        w0 = nwr;
        wr1(12'h0A5, 8'h5A);
        check("R3 register write has no wait", waits, 0);
        check("R1 write strobe count", nwr - w0, 1);
        check("R1 address nibble order", last_wr_addr, 12'h0A5);
        check("R6 oe released during write", oe_err, 0);
        rd1(12'h0A5);
        check("R1 register read data", rbuf[0], 8'h5A);
        check("R3 one wait for one byte", waits, 1);
        check("R6 oe during read", oe_err, 0);
    endtask

    task automatic t_burst;
        int r0;
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        xfer(12'h030, 1'b1, 1'b0, 4, 0);
        check("R7 burst write lands last byte", last_wr_addr, 12'h033);
        r0 = nrd;
        wbuf[0] = 0; wbuf[1] = 0; wbuf[2] = 0; wbuf[3] = 0;
        xfer(12'h030, 1'b0, 1'b0, 4, 0);
        check("R7 burst read byte 0", rbuf[0], 8'h11);
        check("R7 burst read byte 3", rbuf[3], 8'h44);
        check("R3 four waits for four bytes", waits, 4);
        check("R2 local read strobes", nrd - r0, 4);
    endtask

    task automatic t_cfg;
        int w0, r0;
        w0 = nwr; r0 = nrd;
        wr1(12'h00F, 8'h06);
        check("R9 power state from command", pwr_state, 2'd2);
        rd1(12'h00E);
        check("R9 status read", rbuf[0], 8'h02);
        rd1(12'h00F);
        check("R9 command readback", rbuf[0], 8'h06);
        check("R2 no local strobes for config space", (nwr - w0) + (nrd - r0), 0);
    endtask

    task automatic t_sat;
        int w0, r0;
        w0 = nwr; r0 = nrd;
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h03;
        xfer(12'h00E, 1'b1, 1'b0, 3, 0);
        check("R7 config burst holds at top", reg_addr, 12'h00F);
        check("R7 last config byte kept", pwr_state, 2'd3);
        check("R7 no spill into local space", nwr - w0, 0);
        rd1(12'h00F);
        check("R8 status is read-only, command kept", rbuf[0], 8'h03);
        wbuf[0] = 0; wbuf[1] = 0; wbuf[2] = 0;
        xfer(12'hFFE, 1'b0, 1'b0, 3, 0);
        check("R7 local burst holds at 0xFFF", reg_addr, 12'hFFF);
        check("R8 top of local reads zero", rbuf[2], 8'h00);
        check("R8 no strobes beyond implemented range", nrd - r0, 0);
    endtask

    task automatic t_unimpl;
        int w0, r0;
        w0 = nwr; r0 = nrd;
        wr1(12'h1F0, 8'h77);
        check("R8 write above local range discarded", nwr - w0, 0);
        rd1(12'h1F0);
        check("R8 read above local range is zero", rbuf[0], 8'h00);
        wr1(12'h003, 8'h55);
        rd1(12'h003);
        check("R8 unused config reads zero", rbuf[0], 8'h00);
        check("R8 unused config write left power alone", pwr_state, 2'd3);
        check("R8 no strobes", (nwr - w0) + (nrd - r0), 0);
    endtask

    task automatic t_fifo;
        int p0;
        p0 = npop;
        wbuf[0] = 0; wbuf[1] = 0; wbuf[2] = 0;
        xfer(12'h000, 1'b0, 1'b1, 3, 0);
        check("R4 fifo byte 0", rbuf[0], 8'hA0);
        check("R4 fifo byte 2", rbuf[2], 8'hA2);
        check("R4 fifo read no wait", waits, 0);
        check("R4 one pop per byte", npop - p0, 3);
        check("R6 oe during fifo read", oe_err, 0);
    endtask

    task automatic t_fifo_write;
        int p0, w0;
        p0 = npop; w0 = nwr;
        wbuf[0] = 8'h99; wbuf[1] = 8'h98;
        xfer(12'h040, 1'b1, 1'b1, 2, 0);
        check("R5 fifo write pops nothing", npop - p0, 0);
        check("R5 fifo write strobes nothing", nwr - w0, 0);
        wbuf[0] = 0;
        xfer(12'h000, 1'b0, 1'b1, 1, 0);
        check("R5 fifo head unchanged by write", rbuf[0], 8'hA3);
    endtask

    task automatic t_abort;
        int w0;
        wr1(12'h040, 8'h3C);
        w0 = nwr;
        phase(1'b1, 4'h0, 4'h0);
        phase(1'b1, 4'h4, 4'h0);
        phase(1'b1, 4'h0, 4'h0);
        phase(1'b1, 4'h1, 4'h0);
        phase(1'b1, 4'h7, 4'h0);
        phase(1'b0, 4'hE, 4'h0);
        check("R10 aborted write not committed", nwr - w0, 0);
        rd1(12'h040);
        check("R10 register kept after abort", rbuf[0], 8'h3C);
        w0 = nwr;
        wbuf[0] = 8'h12;
        xfer(12'h050, 1'b1, 1'b0, 1, 3);
        check("R10 trailing phases ignored", nwr - w0, 1);
        check("R10 bus released in trailing phases", oe_err, 0);
        rd1(12'h050);
        check("R10 trailing data did not overwrite", rbuf[0], 8'h12);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_single();
                t_burst();
                t_cfg();
                t_sat();
                t_unimpl();
                t_fifo();
                t_fifo_write();
                t_abort();
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule